// File: doc/BRIEF.md
# Eight-Channel Converter Register Command Decoder

This block holds the digital register state of an eight-channel voltage-output converter. It accepts one 24-bit command word per cycle on a valid strobe. Each channel has two registers. The first is a staging (input) register that commands can load without changing the output. The second is an active register whose code drives the analog stage. Each channel also has a power-down flag. The block keeps a chip-wide reference selection (internal or external) and a power state for the internal reference. A serial front end that has assembled the three payload bytes of a write transaction delivers them here as one word.

The code width is a parameter (8, 10 or 12 bits). The channel codes can reset to zero-scale or to mid-scale. The reference can reset to internal or external. All register changes take effect on the clock edge that samples the strobe. Staging lets a host preload several channels and then move them all to the outputs at once, so that the outputs change together.

Top module: `dac_cmd_decoder`

## Requirements
- R1: Word layout: bits [23:20] are the command, bits [19:16] are the channel address, and the code is taken MSB-first from bits [15:16-CODE_W] (bits [15:4] for 12 bits). The remaining low bits have no effect.
- R2: After a synchronous active-low reset, every staging and active code is zero when RESET_MID=0. When RESET_MID=1, only the code MSB is set. All channels are powered up (`ch_pd` all zero). Both `ref_internal` and `ref_powered` equal RESET_REF_INT.
- R3: Command 0000 loads the code into the staging register of the addressed channel(s). Active codes and power flags do not change.
- R4: Command 0001 copies staging to active for the addressed channel(s) and clears their power-down flag.
- R5: Command 0010 loads the staging register of the addressed channel(s). In the same edge, every channel copies staging to active and powers up, and the freshly loaded code is the one that becomes active.
- R6: Command 0011 loads both the staging and the active register of the addressed channel(s) with the code and powers them up.
- R7: Command 0100 sets the power-down flag of the addressed channel(s) and leaves their codes unchanged.
- R8: Command 0101 sets every channel's power-down flag and clears `ref_powered`. The reference selection and all codes do not change.
- R9: Command 0110 sets `ref_internal` and `ref_powered`. Command 0111 clears both.
- R10: Addresses 0000 to 0111 select channels 0 to 7, and 1111 selects all channels. A channel command (0000 to 0100) with an address from 1000 to 1110 changes nothing.
- R11: Command 1111, the reserved commands 1000 to 1110, and any cycle with `cmd_valid` low change no output.
- R12: A command's effect appears on the outputs after the first rising edge that samples `cmd_valid` high, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 24 | Command, address and code word |
| act_codes | output | NUM_CH*CODE_W | Active codes; channel i at [i*CODE_W +: CODE_W] |
| ch_pd | output | NUM_CH | Per-channel power-down flag, bit i = channel i |
| ref_internal | output | 1 | 1 = internal reference selected |
| ref_powered | output | 1 | 1 = internal reference powered |

## Verification
Two things can happen in the same edge. Command 0010 loads one channel's staging register, and the same command updates every channel. The check is that the addressed channel's output shows the new code, not its previous staging value. The bench provokes this by sweeping every command against every address, each time with a different code, so the staging value always differs from the incoming one. It also repeats the case in a long pseudo-random run in which `cmd_valid` stays high across consecutive words. The bench judges each result against a model built from the requirements and samples just before and just after the active edge.

// File: rtl/dacdec_pkg.sv
// Shared command encodings and per-channel control types for the
// converter register command decoder.
package dacdec_pkg;

    typedef enum logic [3:0] {
        OP_LOAD         = 4'h0,
        OP_UPDATE       = 4'h1,
        OP_LOAD_UPD_ALL = 4'h2,
        OP_LOAD_UPD     = 4'h3,
        OP_PD_CH        = 4'h4,
        OP_PD_CHIP      = 4'h5,
        OP_REF_INT      = 4'h6,
        OP_REF_EXT      = 4'h7,
        OP_NOP          = 4'hF
    } op_e;

    localparam logic [3:0] ADDR_ALL = 4'hF;

    // Per-channel strobes: load staging, update active, power down.
    typedef struct packed {
        logic ld;
        logic up;
        logic dn;
    } ch_ctl_t;

    // Chip-wide strobes.
    typedef struct packed {
        logic pd_chip;
        logic ref_int;
        logic ref_ext;
    } glob_ctl_t;

endpackage

// File: rtl/dacdec_cmd_decode.sv
// Splits a command word into its fields and produces one-cycle control
// strobes for each channel and for the chip-wide reference state.
// Assumes a word is acted on only while valid is high. Reserved commands
// and reserved addresses yield no strobe at all.
module dacdec_cmd_decode
    import dacdec_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CODE_W = 12,
    parameter int WORD_W = 24,
    parameter int ADDR_W = 4
) (
    input  logic                       valid,
    input  logic [WORD_W-1:0]          word,
    output ch_ctl_t [NUM_CH-1:0]       ctl,
    output glob_ctl_t                  gctl,
    output logic [CODE_W-1:0]          code
);

    localparam int OP_HI   = WORD_W - 1;
    localparam int ADR_HI  = WORD_W - 5;
    localparam int CODE_HI = WORD_W - 9;

    op_e               op;
    logic [ADDR_W-1:0] adr;
    logic              hit_all;
    logic              addr_ok;
    logic [NUM_CH-1:0] sel;

    // Field extraction: command nibble, address nibble, left-aligned code.
    assign op      = op_e'(word[OP_HI -: 4]);
    assign adr     = word[ADR_HI -: ADDR_W];
    assign code    = word[CODE_HI -: CODE_W];
    assign hit_all = (adr == ADDR_ALL);
    assign addr_ok = hit_all || (int'(adr) < NUM_CH);

    // One select line per channel, set for its own address or for all.
    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
            assign sel[i] = hit_all || (adr == ADDR_W'(i));
        end
    endgenerate

    // Command decode into per-channel and chip-wide strobes.
    always_comb begin
        ctl  = '0;
        gctl = '0;
        if (valid) begin
            case (op)
                OP_LOAD: if (addr_ok) begin
                    for (int i = 0; i < NUM_CH; i++) ctl[i].ld = sel[i];
                end
                OP_UPDATE: if (addr_ok) begin
                    for (int i = 0; i < NUM_CH; i++) ctl[i].up = sel[i];
                end
                OP_LOAD_UPD_ALL: if (addr_ok) begin
                    for (int i = 0; i < NUM_CH; i++) begin
                        ctl[i].ld = sel[i];
                        ctl[i].up = 1'b1;
                    end
                end
                OP_LOAD_UPD: if (addr_ok) begin
                    for (int i = 0; i < NUM_CH; i++) begin
                        ctl[i].ld = sel[i];
                        ctl[i].up = sel[i];
                    end
                end
                OP_PD_CH: if (addr_ok) begin
                    for (int i = 0; i < NUM_CH; i++) ctl[i].dn = sel[i];
                end
                OP_PD_CHIP: begin
                    for (int i = 0; i < NUM_CH; i++) ctl[i].dn = 1'b1;
                    gctl.pd_chip = 1'b1;
                end
                OP_REF_INT: gctl.ref_int = 1'b1;
                OP_REF_EXT: gctl.ref_ext = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dacdec_chan.sv
// One channel: a staging register, an active register and a power-down
// flag. When load and update arrive together, the incoming code goes
// straight to active. Assumes update and power-down never arrive in the
// same cycle (the decoder never issues both).
module dacdec_chan
    import dacdec_pkg::*;
#(
    parameter int CODE_W    = 12,
    parameter bit RESET_MID = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ch_ctl_t           ctl,
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] act,
    output logic              pd
);

    localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};
    localparam logic [CODE_W-1:0] RST_CODE = RESET_MID ? MID_CODE : '0;

    logic [CODE_W-1:0] stage_q;
    logic [CODE_W-1:0] upd_val;

    // Value promoted on update: fresh code if loaded this cycle.
    assign upd_val = ctl.ld ? code : stage_q;

    // Staging register.
    always_ff @(posedge clk) begin
        if (!rst_n)      stage_q <= RST_CODE;
        else if (ctl.ld) stage_q <= code;
    end

    // Active register.
    always_ff @(posedge clk) begin
        if (!rst_n)      act <= RST_CODE;
        else if (ctl.up) act <= upd_val;
    end

    // Power-down flag: update wakes, power-down command sleeps.
    always_ff @(posedge clk) begin
        if (!rst_n)      pd <= 1'b0;
        else if (ctl.up) pd <= 1'b0;
        else if (ctl.dn) pd <= 1'b1;
    end

endmodule

// File: rtl/dacdec_ref.sv
// Chip-wide reference selection and internal-reference power state.
// Assumes at most one reference strobe per cycle.
module dacdec_ref
    import dacdec_pkg::*;
#(
    parameter bit RESET_REF_INT = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  glob_ctl_t gctl,
    output logic      ref_internal,
    output logic      ref_powered
);

    // Reference source selection.
    always_ff @(posedge clk) begin
        if (!rst_n)            ref_internal <= RESET_REF_INT;
        else if (gctl.ref_int) ref_internal <= 1'b1;
        else if (gctl.ref_ext) ref_internal <= 1'b0;
    end

    // Internal reference power.
    always_ff @(posedge clk) begin
        if (!rst_n)                             ref_powered <= RESET_REF_INT;
        else if (gctl.ref_int)                  ref_powered <= 1'b1;
        else if (gctl.ref_ext || gctl.pd_chip)  ref_powered <= 1'b0;
    end

endmodule

// File: rtl/dac_cmd_decoder.sv
// Top level: decodes command words and holds the per-channel and
// chip-wide register state of a multi-channel converter. Every change
// lands on the edge that samples cmd_valid high.
module dac_cmd_decoder
    import dacdec_pkg::*;
#(
    parameter int NUM_CH        = 8,
    parameter int CODE_W        = 12,
    parameter bit RESET_MID     = 1'b0,
    parameter bit RESET_REF_INT = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_valid,
    input  logic [23:0]                cmd_word,
    output logic [NUM_CH*CODE_W-1:0]   act_codes,
    output logic [NUM_CH-1:0]          ch_pd,
    output logic                       ref_internal,
    output logic                       ref_powered
);

    ch_ctl_t [NUM_CH-1:0] ctl;
    glob_ctl_t            gctl;
    logic [CODE_W-1:0]    code;

    dacdec_cmd_decode #(
        .NUM_CH (NUM_CH),
        .CODE_W (CODE_W),
        .WORD_W (24),
        .ADDR_W (4)
    ) u_dec (
        .valid (cmd_valid),
        .word  (cmd_word),
        .ctl   (ctl),
        .gctl  (gctl),
        .code  (code)
    );

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            dacdec_chan #(
                .CODE_W    (CODE_W),
                .RESET_MID (RESET_MID)
            ) u_ch (
                .clk   (clk),
                .rst_n (rst_n),
                .ctl   (ctl[i]),
                .code  (code),
                .act   (act_codes[i*CODE_W +: CODE_W]),
                .pd    (ch_pd[i])
            );
        end
    endgenerate

    dacdec_ref #(
        .RESET_REF_INT (RESET_REF_INT)
    ) u_ref (
        .clk          (clk),
        .rst_n        (rst_n),
        .gctl         (gctl),
        .ref_internal (ref_internal),
        .ref_powered  (ref_powered)
    );

endmodule

// File: rtl/dac_cmd_decoder_chk.sv
// Port-level temporal checks for dac_cmd_decoder, attached by bind.
module dac_cmd_decoder_chk #(
    parameter int NUM_CH = 8,
    parameter int CODE_W = 12
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cmd_valid,
    input logic [23:0]              cmd_word,
    input logic [NUM_CH*CODE_W-1:0] act_codes,
    input logic [NUM_CH-1:0]        ch_pd,
    input logic                     ref_internal,
    input logic                     ref_powered
);

    logic [3:0] op;
    logic [3:0] adr;
    logic       adr_rsvd;
    assign op       = cmd_word[23:20];
    assign adr      = cmd_word[19:16];
    assign adr_rsvd = (adr >= 4'h8) && (adr != 4'hF);

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(act_codes) && $stable(ch_pd)
                       && $stable(ref_internal) && $stable(ref_powered));

    assert_rsvd_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (op >= 4'h8) |=> $stable(act_codes) && $stable(ch_pd)
                       && $stable(ref_internal) && $stable(ref_powered));

    assert_rsvd_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (op <= 4'h4) && adr_rsvd |=> $stable(act_codes)
                       && $stable(ch_pd));

    assert_update_wakes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (op == 4'h1) && (adr == 4'hF) |=> (ch_pd == '0));

    assert_upd_all_wakes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (op == 4'h2) && !adr_rsvd |=> (ch_pd == '0));

    assert_ld_upd_ch0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (op == 4'h3) && ((adr == 4'h0) || (adr == 4'hF))
        |=> act_codes[CODE_W-1:0] == $past(cmd_word[15 -: CODE_W]));

    assert_chip_pd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (op == 4'h5) |=> (&ch_pd) && !ref_powered
                       && $stable(ref_internal) && $stable(act_codes));

    assert_ref_int_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (op == 4'h6) |=> ref_internal && ref_powered);

    assert_ref_ext_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (op == 4'h7) |=> !ref_internal && !ref_powered);

endmodule

bind dac_cmd_decoder dac_cmd_decoder_chk #(
    .NUM_CH (NUM_CH),
    .CODE_W (CODE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_word     (cmd_word),
    .act_codes    (act_codes),
    .ch_pd        (ch_pd),
    .ref_internal (ref_internal),
    .ref_powered  (ref_powered)
);

// File: tb/sim_dac_cmd_decoder.sv
`timescale 1ns/1ps
module sim_dac_cmd_decoder;

    localparam int  NCH  = 8;
    localparam int  CW   = 12;
    localparam bit  RMID = 1'b1;
    localparam bit  RINT = 1'b0;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                cmd_valid = 1'b0;
    logic [23:0]         cmd_word = '0;
    logic [NCH*CW-1:0]   act_codes;
    logic [NCH-1:0]      ch_pd;
    logic                ref_internal;
    logic                ref_powered;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [CW-1:0]  m_stage [NCH];
    logic [CW-1:0]  m_act   [NCH];
    logic [NCH-1:0] m_pd;
    logic           m_ri;
    logic           m_rp;

    always #2.5 clk = ~clk;

    dac_cmd_decoder #(
        .NUM_CH (NCH), .CODE_W (CW), .RESET_MID (RMID), .RESET_REF_INT (RINT)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .cmd_valid (cmd_valid), .cmd_word (cmd_word),
        .act_codes (act_codes), .ch_pd (ch_pd),
        .ref_internal (ref_internal), .ref_powered (ref_powered)
    );

    // R2 reset expectations computed from the parameters.
    task automatic model_reset();
        for (int c = 0; c < NCH; c++) begin
            m_stage[c] = RMID ? CW'(1 << (CW - 1)) : '0;
            m_act[c]   = m_stage[c];
        end
        m_pd = '0;
        m_ri = RINT;
        m_rp = RINT;
    endtask

    // Expected effect of one word, from the requirements.
    task automatic model_step(input logic [23:0] w);
        logic [3:0]    op;
        logic [3:0]    a;
        logic [CW-1:0] d;
        bit            aok;
        op  = w[23:20];
        a   = w[19:16];
        d   = CW'(w[15:0] >> (16 - CW));
        aok = (a < 4'h8) || (a == 4'hF);
        for (int c = 0; c < NCH; c++) begin
            bit hit;
            hit = aok && ((a == 4'hF) || (int'(a) == c));
            case (op)
                4'h0: if (hit) m_stage[c] = d;
                4'h1: if (hit) begin m_act[c] = m_stage[c]; m_pd[c] = 1'b0; end
                4'h2: if (aok) begin
                    if (hit) m_stage[c] = d;
                    m_act[c] = m_stage[c];
                    m_pd[c]  = 1'b0;
                end
                4'h3: if (hit) begin
                    m_stage[c] = d; m_act[c] = d; m_pd[c] = 1'b0;
                end
                4'h4: if (hit) m_pd[c] = 1'b1;
                4'h5: m_pd[c] = 1'b1;
                default: ;
            endcase
        end
        case (op)
            4'h5: m_rp = 1'b0;
            4'h6: begin m_ri = 1'b1; m_rp = 1'b1; end
            4'h7: begin m_ri = 1'b0; m_rp = 1'b0; end
            default: ;
        endcase
    endtask

    function automatic string req_tag(input logic [23:0] w);
        logic [3:0] op;
        logic [3:0] a;
        op = w[23:20];
        a  = w[19:16];
        if (op <= 4'h4 && a >= 4'h8 && a != 4'hF) return "R10";
        case (op)
            4'h0: return "R3,R1";
            4'h1: return "R4";
            4'h2: return "R5,R1";
            4'h3: return "R6,R1";
            4'h4: return "R7";
            4'h5: return "R8";
            4'h6: return "R9";
            4'h7: return "R9";
            default: return "R11";
        endcase
    endfunction

    // Compares all outputs against the model; one vector per call.
    task automatic check_outputs(input string tag);
        logic [NCH*CW-1:0] e;
        for (int c = 0; c < NCH; c++) e[c*CW +: CW] = m_act[c];
        n_vec++;
        if (act_codes !== e || ch_pd !== m_pd ||
            ref_internal !== m_ri || ref_powered !== m_rp) begin
            n_bad++;
            $display("FAIL %s: codes=%h pd=%b ri=%b rp=%b expected codes=%h pd=%b ri=%b rp=%b",
                     tag, act_codes, ch_pd, ref_internal, ref_powered,
                     e, m_pd, m_ri, m_rp);
        end
    endtask

    // Called at a falling edge; R12: no change before the edge.
    task automatic apply(input logic [23:0] w, input bit idle_after);
        cmd_word  = w;
        cmd_valid = 1'b1;
        #1;
        check_outputs("R12 pre-edge");
        @(posedge clk);
        @(negedge clk);
        model_step(w);
        if (idle_after) cmd_valid = 1'b0;
        check_outputs(req_tag(w));
    endtask

    initial begin
        logic [15:0] lfsr;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_outputs("R2 reset");

        // R11: idle cycles with a live-looking word leave state alone.
        cmd_word = 24'h3F_ABCD;
        repeat (2) @(negedge clk);
        check_outputs("R11 idle");

        // Exhaustive command x address sweep with varied codes and don't-care bits.
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 16; a++) begin
                logic [15:0] d;
                d = 16'((op * 16 + a) * 16'h9E37) ^ 16'h5A5A;
                apply({4'(op), 4'(a), d}, 1'b1);
                // Preload fresh staging data so R5 sees a distinct value.
                apply({4'h0, 4'(a), ~d}, 1'b1);
            end
        end

        // Back-to-back pseudo-random words, valid held high.
        lfsr = 16'hACE1;
        for (int k = 0; k < 3000; k++) begin
            logic [3:0] op;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (lfsr[3:0] % 11)
                0, 1:    op = 4'h0;
                2:       op = 4'h1;
                3:       op = 4'h2;
                4:       op = 4'h3;
                5:       op = 4'h4;
                6:       op = 4'h5;
                7:       op = 4'h6;
                8:       op = 4'h7;
                9:       op = 4'hF;
                default: op = 4'h9;
            endcase
            apply({op, lfsr[7:4], lfsr ^ 16'(k)}, k[2:0] == 3'd7);
        end
        cmd_valid = 1'b0;

        // R2: a second reset restores the parameterised state.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        check_outputs("R2 re-reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(190000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R12: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule